// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block frees a two-wire serial bus that a target device is holding low, for example after a transfer was cut off halfway through a byte. A single request starts a fixed override sequence. The block first forces the clock line through nine full clock periods, so that any target still shifting a byte can finish it and release the data line. It then uses the data override to build a stop condition, and finally hands both lines back to the normal byte engine.

Each step of the sequence lasts a fixed time. The step time is given in nanoseconds, and the block converts it to system clock cycles from the clock frequency parameter, rounding up. The block also brings the synchronised line levels and its own override state out in one status word. That word uses the bit layout that the surrounding register logic decodes.

Top module: `bus_clear_seq`

## Requirements
- R1: After a synchronous active-low reset, both override outputs, `busy_o` and `done_o` are low.
- R2: When `start_i` is high at a rising clock edge while the block is idle, the sequence begins at that edge and `busy_o` is high from that edge on.
- R3: The sequence first runs PULSES clock pulses (nine by default). In each pulse the SCL override is low for one step and then high for one step. The SDA override stays low during all pulses.
- R4: Every step lasts exactly D cycles, where D = ceil(CLK_HZ * STEP_NS / 1e9), with a minimum of 1.
- R5: After the last pulse, the SDA override goes high for one step and the SCL override stays high.
- R6: Next, the SCL override goes low for one step while the SDA override stays high.
- R7: Next, both overrides are low for one final step while `busy_o` is still high. Outside a sequence both overrides are always low.
- R8: At the edge that ends the final step, `busy_o` falls and `done_o` is high for exactly one cycle.
- R9: A high `start_i` at any edge where the block is busy, including the edge at which `done_o` rises, is ignored and does not change the override waveform.
- R10: `stat_o` carries the SDA override in bit 8, the SCL override in bit 9, the synchronised SDA level in bit 10 and the synchronised SCL level in bit 11. All other bits are zero. The levels lag the line inputs by SYNC_STAGES clock edges and reset to high.
- R11: A reset during a sequence abandons it, and both overrides are low from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to run the recovery sequence |
| scl_lvl_i | input | 1 | Sensed clock line level |
| sda_lvl_i | input | 1 | Sensed data line level |
| scl_ovr_o | output | 1 | Clock line override enable |
| sda_ovr_o | output | 1 | Data line override enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at sequence end |
| stat_o | output | 12 | Status word with the override and level bits |

## Verification
The bench builds the block with CLK_HZ = 700000, STEP_NS = 5000, PULSES = 9 and SYNC_STAGES = 2. That gives a step of 3.5 cycles before rounding, so the round-up of R4 has to produce a four-cycle step. It also keeps a whole sequence at 84 cycles, so many sequences fit in one run: random start requests land on every step, on the done edge and on a start line held high. A reset in the middle of a run and random line levels feeding the two-stage synchroniser are also exercised.

// File: rtl/bcs_pkg.sv
// Package: shared constants, types and functions of the bus recovery sequencer.
// Assumes: the status word layout is fixed by the register logic that decodes it.
package bcs_pkg;

    localparam int unsigned STAT_W       = 12;
    localparam int unsigned STAT_SDA_OVR = 8;
    localparam int unsigned STAT_SCL_OVR = 9;
    localparam int unsigned STAT_SDA_LVL = 10;
    localparam int unsigned STAT_SCL_LVL = 11;

    typedef struct packed {
        logic scl;
        logic sda;
    } ovr_t;

    // Step length in clock cycles, rounded up, never less than one.
    function automatic int unsigned delay_cycles(input longint unsigned clk_hz,
                                                 input longint unsigned step_ns);
        longint unsigned c;
        c = (clk_hz * step_ns + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

    // Override levels for a step index: first the pulse train, then the stop build-up.
    function automatic ovr_t step_drive(input int unsigned idx, input int unsigned pulses);
        ovr_t o;
        if (idx < 2 * pulses) begin
            o.scl = idx[0];
            o.sda = 1'b0;
        end else if (idx == 2 * pulses) begin
            o.scl = 1'b1;
            o.sda = 1'b1;
        end else if (idx == 2 * pulses + 1) begin
            o.scl = 1'b0;
            o.sda = 1'b1;
        end else begin
            o.scl = 1'b0;
            o.sda = 1'b0;
        end
        return o;
    endfunction

endpackage

// File: rtl/bcs_step_timer.sv
// Module: step timer. It counts the cycles of one step while run_i is high and
// pulses tick_o in the last cycle of each step.
// Assumes: STEP_CYC >= 1. The count restarts from zero whenever run_i is low.
module bcs_step_timer #(
    parameter int unsigned STEP_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEP_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Purpose: advance the in-step cycle count, wrapping at the step end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: mark the last cycle of a step.
    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
    end
endmodule

// File: rtl/bcs_step_seq.sv
// Module: step sequencer. It accepts a start while idle, walks the step index
// on each timer tick and raises a one-cycle done at the end.
// Assumes: tick_i comes from a timer that runs only while busy_o is high.
module bcs_step_seq #(
    parameter int unsigned PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tick_i,
    output logic busy_o,
    output logic done_o,
    output logic scl_ovr_o,
    output logic sda_ovr_o
);
    import bcs_pkg::*;

    localparam int unsigned STEPS = 2 * PULSES + 3;
    localparam int unsigned SW    = $clog2(STEPS);
    localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

    logic [SW-1:0] step_q;
    logic          busy_q;
    logic          done_q;
    ovr_t          drv;

    // Purpose: start, advance and finish the step walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            step_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start_i) begin
                    busy_q <= 1'b1;
                    step_q <= '0;
                end
            end else if (tick_i) begin
                if (step_q == LAST) begin
                    busy_q <= 1'b0;
                    step_q <= '0;
                    done_q <= 1'b1;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end
        end
    end

    // Purpose: decode the override levels from the current step.
    always_comb begin
        drv = step_drive(int'(step_q), PULSES);
        if (!busy_q) drv = '0;
    end

    assign busy_o    = busy_q;
    assign done_o    = done_q;
    assign scl_ovr_o = drv.scl;
    assign sda_ovr_o = drv.sda;
endmodule

// File: rtl/bcs_line_sync.sv
// Module: line level synchroniser. Each sensed line passes through a chain of
// STAGES flops that resets to the idle-high bus level.
// Assumes: STAGES >= 1. The inputs are asynchronous to clk.
module bcs_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o
);
    generate
        if (STAGES == 1) begin : g_one
            logic scl_q, sda_q;
            // Purpose: single capture stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_q <= 1'b1;
                    sda_q <= 1'b1;
                end else begin
                    scl_q <= scl_i;
                    sda_q <= sda_i;
                end
            end
            assign scl_o = scl_q;
            assign sda_o = sda_q;
        end else begin : g_chain
            logic [STAGES-1:0] scl_sh, sda_sh;
            // Purpose: shift both line levels through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[STAGES-2:0], scl_i};
                    sda_sh <= {sda_sh[STAGES-2:0], sda_i};
                end
            end
            assign scl_o = scl_sh[STAGES-1];
            assign sda_o = sda_sh[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/bus_clear_seq.sv
// Module: top of the bus recovery sequencer. On start it drives the override
// waveform (nine clock pulses, then a stop built from the data override) and
// reports the override state and line levels in a status word.
// Assumes: the override outputs act directly on open-drain pad drivers.
module bus_clear_seq #(
    parameter int unsigned CLK_HZ      = 100_000_000,
    parameter int unsigned STEP_NS     = 5000,
    parameter int unsigned PULSES      = 9,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        scl_lvl_i,
    input  logic        sda_lvl_i,
    output logic        scl_ovr_o,
    output logic        sda_ovr_o,
    output logic        busy_o,
    output logic        done_o,
    output logic [11:0] stat_o
);
    import bcs_pkg::*;

    localparam int unsigned STEP_CYC  = delay_cycles(CLK_HZ, STEP_NS);
    localparam int unsigned TOTAL_CYC = (2 * PULSES + 3) * STEP_CYC;

    logic tick;
    logic scl_s, sda_s;

    bcs_step_timer #(.STEP_CYC(STEP_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy_o),
        .tick_o (tick)
    );

    bcs_step_seq #(.PULSES(PULSES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .tick_i    (tick),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .scl_ovr_o (scl_ovr_o),
        .sda_ovr_o (sda_ovr_o)
    );

    bcs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_lvl_i),
        .sda_i (sda_lvl_i),
        .scl_o (scl_s),
        .sda_o (sda_s)
    );

    // Purpose: pack the status word in the layout the register logic decodes.
    always_comb begin
        stat_o               = '0;
        stat_o[STAT_SDA_OVR] = sda_ovr_o;
        stat_o[STAT_SCL_OVR] = scl_ovr_o;
        stat_o[STAT_SDA_LVL] = sda_s;
        stat_o[STAT_SCL_LVL] = scl_s;
    end
endmodule

// File: rtl/bus_clear_seq_chk.sv
// Module: protocol checker for the recovery sequencer, bound to the top.
// Assumes: TOTAL_CYC is the number of cycles for which busy stays high per run.
module bus_clear_seq_chk #(
    parameter int unsigned TOTAL_CYC = 84
) (
    input logic clk,
    input logic rst_n,
    input logic scl_ovr_o,
    input logic sda_ovr_o,
    input logic busy_o,
    input logic done_o
);
    int unsigned run_cnt;

    // Purpose: count the busy cycles of the current run.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_cnt <= 0;
        else if (busy_o) run_cnt <= run_cnt + 1;
        else             run_cnt <= 0;
    end

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!scl_ovr_o && !sda_ovr_o));
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_cnt == TOTAL_CYC && !busy_o));
    p_busy_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (run_cnt < TOTAL_CYC));
    p_sda_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_ovr_o) |-> scl_ovr_o);
    p_stop_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_ovr_o) |-> !scl_ovr_o);
endmodule

bind bus_clear_seq bus_clear_seq_chk #(.TOTAL_CYC(TOTAL_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_ovr_o (scl_ovr_o),
    .sda_ovr_o (sda_ovr_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
);

// File: tb/bus_clear_seq_test.sv
module bus_clear_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int P          = 9;
    localparam int EXP_D      = 4;   // ceil(700000 * 5000 / 1e9) = ceil(3.5)
    localparam int N_STEPS    = 2 * P + 3;
    localparam int LAST_N     = N_STEPS * EXP_D - 1;
    localparam int S          = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic scl_lvl_i = 1'b1;
    logic sda_lvl_i = 1'b1;
    logic scl_ovr_o, sda_ovr_o, busy_o, done_o;
    logic [11:0] stat_o;

    int total = 0;
    int bad = 0;
    bit armed = 0;

    // bench model
    bit m_busy = 0;
    bit m_done = 0;
    int m_n = 0;
    bit prev_start_busy = 0;
    bit [S-1:0] h_scl = '1;
    bit [S-1:0] h_sda = '1;

    bus_clear_seq #(.CLK_HZ(700_000), .STEP_NS(5000), .PULSES(P), .SYNC_STAGES(S)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .scl_lvl_i(scl_lvl_i), .sda_lvl_i(sda_lvl_i),
        .scl_ovr_o(scl_ovr_o), .sda_ovr_o(sda_ovr_o),
        .busy_o(busy_o), .done_o(done_o), .stat_o(stat_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic bit exp_scl(input bit b, input int n);
        int st;
        if (!b) return 1'b0;
        st = n / EXP_D;
        if (st < 2 * P) return st[0];
        return st == 2 * P;
    endfunction

    function automatic bit exp_sda(input bit b, input int n);
        int st;
        if (!b) return 1'b0;
        st = n / EXP_D;
        return (st == 2 * P) || (st == 2 * P + 1);
    endfunction

    function automatic string ovr_tag(input bit b, input int n);
        int st;
        if (!b) return "R7";
        st = n / EXP_D;
        if (st < 2 * P) return "R3/R4";
        if (st == 2 * P) return "R5";
        if (st == 2 * P + 1) return "R6";
        return "R7";
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_outputs(input string override_tag);
        bit es, ed;
        logic [11:0] est;
        es = exp_scl(m_busy, m_n);
        ed = exp_sda(m_busy, m_n);
        est = '0;
        est[8] = ed; est[9] = es; est[10] = h_sda[S-1]; est[11] = h_scl[S-1];
        chk({scl_ovr_o, sda_ovr_o} == {es, ed},
            (override_tag != "") ? override_tag : (prev_start_busy ? "R9" : ovr_tag(m_busy, m_n)),
            {scl_ovr_o, sda_ovr_o}, {es, ed});
        chk(busy_o == m_busy, (override_tag != "") ? override_tag : "R2", busy_o, m_busy);
        chk(done_o == m_done, (override_tag != "") ? override_tag : "R8", done_o, m_done);
        chk(stat_o == est, "R10", stat_o, est);
    endtask

    // one clock: check at negedge, drive, then update the model at posedge
    task automatic cyc(input logic s, input logic r, input string tag);
        bit sl, dl;
        @(negedge clk);
        if (armed) check_outputs(tag);
        sl = 1'($urandom_range(0, 1));
        dl = 1'($urandom_range(0, 1));
        start_i = s; rst_n = r; scl_lvl_i = sl; sda_lvl_i = dl;
        @(posedge clk);
        armed = 1;
        prev_start_busy = 0;
        if (!r) begin
            m_busy = 0; m_done = 0; m_n = 0; h_scl = '1; h_sda = '1;
        end else begin
            h_scl = {h_scl[S-2:0], sl};
            h_sda = {h_sda[S-2:0], dl};
            if (m_busy) begin
                prev_start_busy = s;
                if (m_n == LAST_N) begin m_busy = 0; m_done = 1; m_n = 0; end
                else begin m_n++; m_done = 0; end
            end else begin
                m_done = 0;
                if (s) begin m_busy = 1; m_n = 0; end
            end
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        // R1: reset state
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, "R1");
        cyc(1'b0, 1'b1, "R1");
        // directed: one clean run (R2..R8)
        cyc(1'b1, 1'b1, "");
        for (int i = 0; i < LAST_N + 4; i++) cyc(1'b0, 1'b1, "");
        // directed: start held high across two runs and the done edge (R9)
        for (int i = 0; i < 2 * (LAST_N + 2) + 3; i++) cyc(1'b1, 1'b1, "");
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, "");
        // directed: reset in the middle of a run (R11)
        cyc(1'b1, 1'b1, "");
        for (int i = 0; i < 2 * P * EXP_D + 2; i++) cyc(1'b0, 1'b1, "");
        cyc(1'b0, 1'b0, "R11");
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, "R11");
        // random runs with stray start requests
        for (int run = 0; run < 40; run++) begin
            int gap;
            gap = $urandom_range(0, 5);
            for (int i = 0; i < gap; i++) cyc(1'b0, 1'b1, "");
            cyc(1'b1, 1'b1, "");
            for (int i = 0; i < LAST_N + 2; i++)
                cyc(1'($urandom_range(0, 3) == 0), 1'b1, "");
        end
        cyc(1'b0, 1'b1, "");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule